// File: doc/BRIEF.md
# Processor exception entry sequencer

This block sits beside the register file of a 32-bit processor core and carries out the entry into an exception. Four kinds of request reach it: reset, fast interrupt, normal interrupt and data abort. In each clock cycle it picks at most one request by fixed priority. Requests whose disable flag is set in the live status word are left out. It then issues the complete entry as one set of single-cycle write strobes.

For the granted exception it builds four writes:

- a return link for the banked link register of the target mode;
- a copy of the live status word for the banked saved-status register of that mode;
- a rewritten status word with the new mode, the raised disable flags and the state bit cleared;
- a program-counter redirect to the exception vector.

The link offset depends only on the kind of exception. It is the same whether the core ran the 32-bit or the 16-bit instruction set, so a handler can return with one fixed subtraction in either case.

The core supplies the request lines, the current PC, the current status word and the live instruction-set state bit. It applies the strobes to its banked registers and its fetch unit. Decode, the return path and the pipeline stay in the core.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is held, and on the first edges after its release, every write strobe (link, saved status, status, PC redirect) is low.
- R2: When several requests are active, the one taken is chosen in this order: reset first, then data abort, then fast interrupt, then normal interrupt. At most one exception is taken per edge.
- R3: A fast interrupt request is ignored while status bit 6 is 1, and a normal interrupt request is ignored while status bit 7 is 1. Reset and data abort are taken whatever those bits hold.
- R4: For a fast or normal interrupt the link value is the current PC plus 4. For a data abort it is the current PC plus 8, wrapping modulo 2^32. The value does not depend on the instruction-set state input.
- R5: A reset exception issues no link write and no saved-status write. It still rewrites the status word and redirects the PC.
- R6: Every non-reset exception writes a saved status equal to the current status word with bit 5 replaced by the instruction-set state input.
- R7: Link and saved-status writes name their bank with the 5-bit mode code of the target: 10001 for fast interrupt, 10010 for normal interrupt, 10111 for abort and 10011 for supervisor (reset).
- R8: The new status word carries the target mode code in bits 4:0 and has bit 7 set and bit 5 cleared. Bit 6 is set for reset and fast interrupt and otherwise kept. Bits 31:8 are kept.
- R9: The PC redirect targets 0x00 for reset, 0x10 for data abort, 0x18 for normal interrupt and 0x1C for fast interrupt.
- R10: Strobes are registered. They are high exactly in the cycle after the edge that samples an accepted request, and low after any edge that sees no accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_rst | input | 1 | Reset exception request |
| req_abort | input | 1 | Data abort request |
| req_fast | input | 1 | Fast interrupt request |
| req_norm | input | 1 | Normal interrupt request |
| cur_pc | input | 32 | Address the link value is based on |
| cur_psr | input | 32 | Current status word |
| in_narrow | input | 1 | Live instruction-set state (1 = 16-bit) |
| lr_we | output | 1 | Banked link register write strobe |
| lr_bank | output | 5 | Mode code of the link register written |
| lr_wdata | output | 32 | Return link value |
| sps_we | output | 1 | Banked saved-status write strobe |
| sps_bank | output | 5 | Mode code of the saved-status register written |
| sps_wdata | output | 32 | Saved status value |
| psr_we | output | 1 | Status word write strobe |
| psr_wdata | output | 32 | New status word |
| pc_redir | output | 1 | PC redirect strobe |
| pc_target | output | 32 | Exception vector address |

## Verification
The bench looks for the following corner cases and the failure each would expose:

- **Every request active at once.** A wrong priority order would branch to the abort or interrupt vector instead of the reset vector.
- **Masked fast interrupt with a normal interrupt pending.** A design that ignores the mask, or lets the mask kill every interrupt, would take the wrong exception or none at all.
- **Data abort with both disable bits set.** A design that masks aborts would miss the entry entirely.
- **Aborts and interrupts in 16-bit state.** A design that adjusts the offset for the state would produce links 2 or 4 lower.
- **PC near the top of the address space.** This checks the wrapping add.
- **Reset entries.** These must leave the link and saved-status strobes low.
- **Idle cycles after an entry.** These show that the strobes fall after one cycle instead of sticking high.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [2:0] {
    EXC_NONE,
    EXC_RST,
    EXC_ABT,
    EXC_FIQ,
    EXC_IRQ
  } exc_kind_t;

  localparam int unsigned MODE_W = 5;
  localparam int unsigned N_SRC  = 4;

  // Source index order is the priority order (0 wins)
  localparam int unsigned SRC_RST = 0;
  localparam int unsigned SRC_ABT = 1;
  localparam int unsigned SRC_FIQ = 2;
  localparam int unsigned SRC_IRQ = 3;

  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;

  function automatic logic [MODE_W-1:0] mode_of(exc_kind_t k);
    case (k)
      EXC_FIQ: return MODE_FIQ;
      EXC_IRQ: return MODE_IRQ;
      EXC_ABT: return MODE_ABT;
      default: return MODE_SVC;
    endcase
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int unsigned NSRC = N_SRC
) (
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] blocked,
  output logic [NSRC-1:0] grant,
  output exc_kind_t       kind
);

  logic [NSRC-1:0] elig;
  logic [NSRC-1:0] lower_won;

  assign elig = req & ~blocked;

  // Prefix chain: a source wins only if no higher-priority source is eligible
  for (genvar i = 0; i < NSRC; i++) begin : g_chain
    if (i == 0) begin : g_head
      assign lower_won[i] = 1'b0;
    end else begin : g_link
      assign lower_won[i] = lower_won[i-1] | elig[i-1];
    end
    assign grant[i] = elig[i] & ~lower_won[i];
  end

  always_comb begin
    kind = EXC_NONE;
    if (grant[SRC_RST])      kind = EXC_RST;
    else if (grant[SRC_ABT]) kind = EXC_ABT;
    else if (grant[SRC_FIQ]) kind = EXC_FIQ;
    else if (grant[SRC_IRQ]) kind = EXC_IRQ;
  end

endmodule

// File: rtl/exc_link_calc.sv
module exc_link_calc
  import exc_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter int unsigned INT_OFS = 4,
  parameter int unsigned ABT_OFS = 8
) (
  input  exc_kind_t      kind,
  input  logic [W-1:0]   pc,
  output logic           link_vld,
  output logic [W-1:0]   link_val
);

  localparam logic [W-1:0] INT_ADD = W'(INT_OFS);
  localparam logic [W-1:0] ABT_ADD = W'(ABT_OFS);

  logic [W-1:0] offset;

  always_comb begin
    offset   = '0;
    link_vld = 1'b0;
    case (kind)
      EXC_FIQ, EXC_IRQ: begin offset = INT_ADD; link_vld = 1'b1; end
      EXC_ABT:          begin offset = ABT_ADD; link_vld = 1'b1; end
      default:          begin offset = '0;      link_vld = 1'b0; end
    endcase
  end

  assign link_val = pc + offset;

endmodule

// File: rtl/exc_psr_former.sv
module exc_psr_former
  import exc_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned T_POS = 5,
  parameter int unsigned F_POS = 6,
  parameter int unsigned I_POS = 7
) (
  input  exc_kind_t    kind,
  input  logic [W-1:0] psr_in,
  input  logic         narrow,
  output logic [W-1:0] saved,
  output logic [W-1:0] forced
);

  logic set_f;
  assign set_f = (kind == EXC_RST) || (kind == EXC_FIQ);

  always_comb begin
    saved        = psr_in;
    saved[T_POS] = narrow;
  end

  always_comb begin
    forced               = psr_in;
    forced[MODE_W-1:0]   = mode_of(kind);
    forced[T_POS]        = 1'b0;
    forced[I_POS]        = 1'b1;
    if (set_f) forced[F_POS] = 1'b1;
  end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter int unsigned INT_OFS = 4,
  parameter int unsigned ABT_OFS = 8,
  parameter int unsigned T_POS   = 5,
  parameter int unsigned F_POS   = 6,
  parameter int unsigned I_POS   = 7,
  parameter logic [31:0] VEC_RST = 32'h0000_0000,
  parameter logic [31:0] VEC_ABT = 32'h0000_0010,
  parameter logic [31:0] VEC_IRQ = 32'h0000_0018,
  parameter logic [31:0] VEC_FIQ = 32'h0000_001C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_rst,
  input  logic              req_abort,
  input  logic              req_fast,
  input  logic              req_norm,
  input  logic [W-1:0]      cur_pc,
  input  logic [W-1:0]      cur_psr,
  input  logic              in_narrow,
  output logic              lr_we,
  output logic [MODE_W-1:0] lr_bank,
  output logic [W-1:0]      lr_wdata,
  output logic              sps_we,
  output logic [MODE_W-1:0] sps_bank,
  output logic [W-1:0]      sps_wdata,
  output logic              psr_we,
  output logic [W-1:0]      psr_wdata,
  output logic              pc_redir,
  output logic [W-1:0]      pc_target
);

  // Reset: asserted asynchronously, released on the clock
  logic rst_m_n, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_n <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rst_m_n <= 1'b1;
      rst_s_n <= rst_m_n;
    end
  end

  // Request arbitration
  logic [N_SRC-1:0] req_vec, blk_vec, grant;
  exc_kind_t        kind;

  always_comb begin
    req_vec          = '0;
    blk_vec          = '0;
    req_vec[SRC_RST] = req_rst;
    req_vec[SRC_ABT] = req_abort;
    req_vec[SRC_FIQ] = req_fast;
    req_vec[SRC_IRQ] = req_norm;
    blk_vec[SRC_FIQ] = cur_psr[F_POS];
    blk_vec[SRC_IRQ] = cur_psr[I_POS];
  end

  exc_arbiter #(.NSRC(N_SRC)) i_arb (
    .req     (req_vec),
    .blocked (blk_vec),
    .grant   (grant),
    .kind    (kind)
  );

  logic         link_vld;
  logic [W-1:0] link_val;

  exc_link_calc #(.W(W), .INT_OFS(INT_OFS), .ABT_OFS(ABT_OFS)) i_link (
    .kind     (kind),
    .pc       (cur_pc),
    .link_vld (link_vld),
    .link_val (link_val)
  );

  logic [W-1:0] saved_val, forced_val;

  exc_psr_former #(.W(W), .T_POS(T_POS), .F_POS(F_POS), .I_POS(I_POS)) i_psr (
    .kind   (kind),
    .psr_in (cur_psr),
    .narrow (in_narrow),
    .saved  (saved_val),
    .forced (forced_val)
  );

  // Next-state
  logic              take;
  logic              lr_we_d, sps_we_d, psr_we_d, pc_redir_d;
  logic [MODE_W-1:0] bank_d;
  logic [W-1:0]      vec_d;

  assign take   = |grant;
  assign bank_d = mode_of(kind);

  always_comb begin
    case (kind)
      EXC_ABT: vec_d = W'(VEC_ABT);
      EXC_FIQ: vec_d = W'(VEC_FIQ);
      EXC_IRQ: vec_d = W'(VEC_IRQ);
      default: vec_d = W'(VEC_RST);
    endcase
  end

  always_comb begin
    lr_we_d    = take && link_vld;
    sps_we_d   = take && (kind != EXC_RST);
    psr_we_d   = take;
    pc_redir_d = take;
  end

  // Strobe registers: one cycle per accepted exception
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      lr_we    <= 1'b0;
      sps_we   <= 1'b0;
      psr_we   <= 1'b0;
      pc_redir <= 1'b0;
    end else begin
      lr_we    <= lr_we_d;
      sps_we   <= sps_we_d;
      psr_we   <= psr_we_d;
      pc_redir <= pc_redir_d;
    end
  end

  // Data registers: loaded only when an exception is accepted
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      lr_bank   <= '0;
      lr_wdata  <= '0;
      sps_bank  <= '0;
      sps_wdata <= '0;
      psr_wdata <= '0;
      pc_target <= '0;
    end else if (take) begin
      lr_bank   <= bank_d;
      lr_wdata  <= link_val;
      sps_bank  <= bank_d;
      sps_wdata <= saved_val;
      psr_wdata <= forced_val;
      pc_target <= vec_d;
    end
  end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned T_POS = 5,
  parameter int unsigned F_POS = 6,
  parameter int unsigned I_POS = 7
) (
  input logic              clk,
  input logic              rst_s_n,
  input logic              req_rst,
  input logic              req_abort,
  input logic              req_fast,
  input logic              req_norm,
  input logic [W-1:0]      cur_pc,
  input logic [W-1:0]      cur_psr,
  input logic              lr_we,
  input logic [MODE_W-1:0] lr_bank,
  input logic [W-1:0]      lr_wdata,
  input logic              sps_we,
  input logic [MODE_W-1:0] sps_bank,
  input logic              psr_we,
  input logic [W-1:0]      psr_wdata,
  input logic              pc_redir,
  input logic [W-1:0]      pc_target
);

  logic seen;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) seen <= 1'b0;
    else          seen <= 1'b1;
  end

  // R10
  psr_pc_pair_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    psr_we == pc_redir);

  // R5
  link_needs_psr_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (lr_we || sps_we) |-> psr_we);

  // R2
  rst_wins_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    seen && req_rst |=> pc_redir && pc_target == '0 && !lr_we && !sps_we);

  // R3
  norm_masked_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    seen && req_norm && cur_psr[I_POS] && !req_rst && !req_abort && !req_fast |=> !psr_we);

  // R4
  abort_link_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    seen && req_abort && !req_rst |=> lr_we && lr_wdata == $past(cur_pc) + W'(8));

  // R8
  forced_bits_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    psr_we |-> psr_wdata[I_POS] && !psr_wdata[T_POS] && psr_wdata[4]);

  // R7
  bank_match_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    lr_we && sps_we |-> lr_bank == sps_bank && lr_bank == psr_wdata[MODE_W-1:0]);

endmodule

bind exc_entry_seq exc_entry_chk #(.W(W), .T_POS(T_POS), .F_POS(F_POS), .I_POS(I_POS)) i_chk (
  .clk       (clk),
  .rst_s_n   (rst_s_n),
  .req_rst   (req_rst),
  .req_abort (req_abort),
  .req_fast  (req_fast),
  .req_norm  (req_norm),
  .cur_pc    (cur_pc),
  .cur_psr   (cur_psr),
  .lr_we     (lr_we),
  .lr_bank   (lr_bank),
  .lr_wdata  (lr_wdata),
  .sps_we    (sps_we),
  .sps_bank  (sps_bank),
  .psr_we    (psr_we),
  .psr_wdata (psr_wdata),
  .pc_redir  (pc_redir),
  .pc_target (pc_target)
);

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_rst = 1'b0, req_abort = 1'b0, req_fast = 1'b0, req_norm = 1'b0;
  logic [31:0] cur_pc = '0, cur_psr = '0;
  logic        in_narrow = 1'b0;
  logic        lr_we, sps_we, psr_we, pc_redir;
  logic [4:0]  lr_bank, sps_bank;
  logic [31:0] lr_wdata, sps_wdata, psr_wdata, pc_target;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  exc_entry_seq i_exc_entry_seq (
    .clk(clk), .rst_n(rst_n),
    .req_rst(req_rst), .req_abort(req_abort), .req_fast(req_fast), .req_norm(req_norm),
    .cur_pc(cur_pc), .cur_psr(cur_psr), .in_narrow(in_narrow),
    .lr_we(lr_we), .lr_bank(lr_bank), .lr_wdata(lr_wdata),
    .sps_we(sps_we), .sps_bank(sps_bank), .sps_wdata(sps_wdata),
    .psr_we(psr_we), .psr_wdata(psr_wdata),
    .pc_redir(pc_redir), .pc_target(pc_target)
  );

  typedef struct packed {
    logic        lr_we, sps_we, psr_we, pc_redir;
    logic [4:0]  bank;
    logic [31:0] link, saved, newpsr, vec;
  } exp_t;

  function automatic exp_t model(logic r, logic a, logic f, logic n,
                                 logic [31:0] pc, logic [31:0] psr, logic nar);
    exp_t e;
    int k; // 0 none, 1 rst, 2 abt, 3 fiq, 4 irq
    e = '0;
    if (r) k = 1;
    else if (a) k = 2;
    else if (f && !psr[6]) k = 3;
    else if (n && !psr[7]) k = 4;
    else k = 0;
    if (k != 0) begin
      e.psr_we = 1; e.pc_redir = 1;
      e.lr_we = (k != 1); e.sps_we = (k != 1);
      case (k)
        1: begin e.bank = 5'b10011; e.vec = 32'h00; end
        2: begin e.bank = 5'b10111; e.vec = 32'h10; e.link = pc + 32'd8; end
        3: begin e.bank = 5'b10001; e.vec = 32'h1C; e.link = pc + 32'd4; end
        default: begin e.bank = 5'b10010; e.vec = 32'h18; e.link = pc + 32'd4; end
      endcase
      e.saved = {psr[31:6], nar, psr[4:0]};
      e.newpsr = {psr[31:8], 1'b1, (k == 1 || k == 3) ? 1'b1 : psr[6], 1'b0, e.bank};
    end
    return e;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive at negedge, sample just after the following posedge
  task automatic step(string tag, logic r, logic a, logic f, logic n,
                      logic [31:0] pc, logic [31:0] psr, logic nar);
    exp_t e;
    @(negedge clk);
    req_rst = r; req_abort = a; req_fast = f; req_norm = n;
    cur_pc = pc; cur_psr = psr; in_narrow = nar;
    e = model(r, a, f, n, pc, psr, nar);
    @(posedge clk);
    #1;
    chk({tag, "/R10"}, "psr_we", 32'(psr_we), 32'(e.psr_we));
    chk({tag, "/R10"}, "pc_redir", 32'(pc_redir), 32'(e.pc_redir));
    chk({tag, "/R5"}, "lr_we", 32'(lr_we), 32'(e.lr_we));
    chk({tag, "/R5"}, "sps_we", 32'(sps_we), 32'(e.sps_we));
    if (e.pc_redir) begin
      chk({tag, "/R9"}, "pc_target", pc_target, e.vec);
      chk({tag, "/R8"}, "psr_wdata", psr_wdata, e.newpsr);
    end
    if (e.lr_we) begin
      chk({tag, "/R4"}, "lr_wdata", lr_wdata, e.link);
      chk({tag, "/R7"}, "lr_bank", 32'(lr_bank), 32'(e.bank));
      chk({tag, "/R7"}, "sps_bank", 32'(sps_bank), 32'(e.bank));
      chk({tag, "/R6"}, "sps_wdata", sps_wdata, e.saved);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    // R1: strobes low during reset
    chk("R1", "strobes in reset", 32'({lr_we, sps_we, psr_we, pc_redir}), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: low after release with no request
    chk("R1", "strobes after release", 32'({lr_we, sps_we, psr_we, pc_redir}), 32'd0);

    // R2: everything requested, reset wins
    step("R2_all", 1, 1, 1, 1, 32'h0000_4000, 32'h0000_0010, 0);
    // R2: abort beats both interrupts
    step("R2_abt", 0, 1, 1, 1, 32'h0000_8000, 32'hF000_0010, 1);
    // R2: fast beats normal
    step("R2_fiq", 0, 0, 1, 1, 32'h0000_1230, 32'h0000_001F, 0);
    // R10: idle edge drops strobes
    step("R10_idle", 0, 0, 0, 0, 32'h0, 32'h0, 0);
    // R3: fast masked, normal taken
    step("R3_fmask", 0, 0, 1, 1, 32'h0000_2000, 32'h0000_0053, 0);
    // R3: both masked, nothing taken
    step("R3_both", 0, 0, 1, 1, 32'h0000_2000, 32'h0000_00D3, 0);
    // R3: abort not masked
    step("R3_abt", 0, 1, 0, 0, 32'h0000_3000, 32'h0000_00D3, 0);
    // R4: 16-bit state, same offsets
    step("R4_nar_irq", 0, 0, 0, 1, 32'h0000_0102, 32'h0000_0030, 1);
    step("R4_nar_abt", 0, 1, 0, 0, 32'h0000_0106, 32'h0000_0030, 1);
    // R4: wrap at the top of the address space
    step("R4_wrap", 0, 1, 0, 0, 32'hFFFF_FFFC, 32'h0000_0010, 0);
    // R5: reset with masks set still taken, no link write
    step("R5_rst", 1, 0, 0, 0, 32'h1234_5678, 32'hA5A5_A5FF, 1);
    step("R10_idle2", 0, 0, 1, 1, 32'h0, 32'h0000_00C0, 0);

    for (int i = 0; i < 400; i++) begin
      logic r, a, f, n, nar;
      logic [31:0] pc, psr;
      r   = ($urandom % 16) == 0;
      a   = ($urandom % 4) == 0;
      f   = ($urandom % 3) == 0;
      n   = ($urandom % 2) == 0;
      nar = 1'($urandom);
      pc  = $urandom;
      psr = $urandom;
      step("R2_rand", r, a, f, n, pc, psr, nar);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule